// File: doc/BRIEF.md
# System Address Interleave Decoder

This block turns a physical system address into a destination triple: a socket id, a memory controller index and a channel index. It holds a set of decode tables for each of up to four nodes. Each set has a range table, one interleave word per range, a route word and a node identity word. Software fills these through a one-cycle write port before traffic starts. A request address enters with a valid/ready handshake. The block then walks the range table of the home set (set 0) one entry per clock. It picks an interleave target from the matching range. If the target points at another node, it starts the walk again once in that node's tables. It then folds the address into a logical channel and translates that channel through the route word.

Only one lookup is in flight at a time. The result is held on the response port until the consumer takes it. Every failed lookup still returns a response, with the error flag raised and all other fields zero. Translation inside a channel (ranks, banks, rows) belongs to a later stage.

Top module: `sai_decoder`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `resp_valid` is 0.
- R2: A request fails at once when its address is at or above the high-memory top, or when it is at or above the low-memory top and below 4 GiB. Both tops are held in units of 64 MiB, so the byte boundary is the register value times 2^26.
- R3: The 24 range words of a set are tried in order from slot 0, and the first hit wins. A range's upper limit is word[26:7]·2^26 + (2^26−1). A range hits when word[0] is 1 and lower ≤ address ≤ limit. The lower bound starts at 0 and becomes limit+1 after every slot, whether the slot is enabled or not. A lookup with no hit fails.
- R4: Range word bits [2:1] pick a 3-bit index: 0 → addr[8:6], 1 → addr[10:8], 2 → addr[14:12], 3 → addr[32:30]. The target is nibble number index (bits 4·index+3 down to 4·index) of that range's interleave word.
- R5: A target whose bit 3 is 0 is remote. The walk restarts at slot 0, with lower bound 0, in the lowest-numbered set whose node word has its present bit (bit 3) set and its id (bits [2:0]) equal to target[2:0].
- R6: A remote target met after a restart fails the lookup. A remote target that names no present set also fails it.
- R7: When range bit 27 is 0, the logical channel L equals target[2:0]. When it is 1, bits [31:30] pick a shift of 6, 8 or 12, and the value 3 fails the lookup. A remote target is handled before this check.
- R8: In modulo mode, with x = addr >> shift, bits [6:5] pick a value v: 0 → x mod 3; 1 → x mod 2; 2 → 2 if x is odd, else 1; 3 → 2 if x is odd, else 0. Then L = 2·v + target[0].
- R9: A successful response carries the controller as route[3L+2:3L], the channel as route[2L+19:2L+18] (route bits above 31 read as 0), and the socket as the id of the set where the walk ended.
- R10: A failed response has `resp_err` = 1 and socket, controller and channel all 0.
- R11: `req_ready` is high only while idle. A response stays valid and unchanged until `resp_ready` is high at a clock edge. After that edge the block is idle again.
- R12: Counting clock edges after the accepting edge, the response is valid after: 0 edges for an R2 failure; 24 edges for each table walked without a hit; and m+2 edges for each table that hits at slot m.
- R13: A configuration write happens on a clock edge with `cfg_we` high. `cfg_kind` selects the target register: 0 range word [set][slot], 1 interleave word [set][slot], 2 route word [set], 3 node word [set], 4 low-memory top, 5 high-memory top. Slots of 24 and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind selector (R13) |
| cfg_set | input | 2 | Node set for per-set kinds |
| cfg_slot | input | 5 | Range slot for range and interleave words |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 40 | Physical system address |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_err | output | 1 | Lookup failed |
| resp_socket | output | 3 | Socket id |
| resp_ctrl | output | 3 | Memory controller index |
| resp_chan | output | 2 | Channel index |

## Verification
The time until a result is valid depends on the path the lookup takes. An R2 rejection is valid at the first sample after the accepting edge. A table walk without a hit costs 24 edges. A walk that hits at slot m costs m+2 edges, and a redirected lookup adds the cost of its second walk. The bench drives each request, samples at falling edges, and counts edges until `resp_valid` appears. It compares that count with the latency its own model predicts for the same path, together with the error flag and the three result fields. It does this over a sweep that touches every slot of a mixed configuration. Response holding is checked by keeping `resp_ready` low for several sampled cycles.

// File: rtl/sai_pkg.sv
package sai_pkg;

  // Configuration register kinds (R13)
  typedef enum logic [2:0] {
    K_RANGE   = 3'd0,
    K_ILV     = 3'd1,
    K_ROUTE   = 3'd2,
    K_NODE    = 3'd3,
    K_LOWTOP  = 3'd4,
    K_HIGHTOP = 3'd5
  } cfg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_RESP    = 2'd3
  } fsm_e;

  typedef struct packed {
    logic       err;
    logic [2:0] socket;
    logic [2:0] ctrl;
    logic [1:0] chan;
  } result_t;

  localparam int GRAIN_SH = 26;

  // Inclusive upper limit of a range word (R3)
  function automatic logic [63:0] range_limit(input logic [31:0] w);
    return {18'd0, w[26:7], {GRAIN_SH{1'b1}}};
  endfunction

  // Interleave index pick (R4)
  function automatic logic [2:0] ilv_index(input logic [63:0] a, input logic [1:0] g);
    logic [2:0] r;
    case (g)
      2'd0:    r = a[8:6];
      2'd1:    r = a[10:8];
      2'd2:    r = a[14:12];
      default: r = a[32:30];
    endcase
    return r;
  endfunction

  // Residue mod 3, one bit per step from the top (R8)
  function automatic logic [1:0] mod3(input logic [63:0] v, input int nbits);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 63; i >= 0; i--) begin
      if (i < nbits) begin
        case ({r, v[i]})
          3'b001:  r = 2'd1;
          3'b010:  r = 2'd2;
          3'b100:  r = 2'd1;
          3'b101:  r = 2'd2;
          default: r = 2'd0;
        endcase
      end
    end
    return r;
  endfunction

  // Modulo-mode value before the parity bit is appended (R8)
  function automatic logic [1:0] fold_value(input logic [1:0] sel, input logic [1:0] m3,
                                            input logic odd);
    logic [1:0] v;
    case (sel)
      2'd0:    v = m3;
      2'd1:    v = {1'b0, odd};
      2'd2:    v = odd ? 2'd2 : 2'd1;
      default: v = odd ? 2'd2 : 2'd0;
    endcase
    return v;
  endfunction

  // Route word translation (R9)
  function automatic logic [2:0] route_ctrl(input logic [31:0] r, input logic [2:0] l);
    return r[3*l +: 3];
  endfunction

  function automatic logic [1:0] route_chan(input logic [31:0] r, input logic [2:0] l);
    logic [33:0] e;
    e = {2'b00, r};
    return e[18 + 2*l +: 2];
  endfunction

endpackage

// File: rtl/sai_cfg_store.sv
module sai_cfg_store
  import sai_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int RANGES = 24,
  parameter int SET_W  = 2,
  parameter int SLOT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [2:0]                  cfg_kind,
  input  logic [SET_W-1:0]            cfg_set,
  input  logic [SLOT_W-1:0]           cfg_slot,
  input  logic [31:0]                 cfg_wdata,
  input  logic [SET_W-1:0]            rd_set,
  input  logic [SLOT_W-1:0]           rd_slot,
  output logic [31:0]                 rd_range,
  output logic [31:0]                 rd_ilv,
  output logic [31:0]                 rd_route,
  output logic [2:0]                  rd_src,
  output logic [NODES-1:0][2:0]       node_src,
  output logic [NODES-1:0]            node_pres,
  output logic [31:0]                 low_top,
  output logic [31:0]                 high_top
);

  logic slot_ok;
  assign slot_ok = (32'(cfg_slot) < RANGES);

  logic [NODES-1:0][31:0] range_by_set;
  logic [NODES-1:0][31:0] ilv_by_set;
  logic [NODES-1:0][31:0] route_by_set;

  // R13: one register file per node set
  for (genvar s = 0; s < NODES; s++) begin : g_set
    logic [31:0] rng_q [RANGES];
    logic [31:0] ilv_q [RANGES];
    logic [31:0] route_q;
    logic [3:0]  node_q;
    logic        hit_s;

    assign hit_s = cfg_we && (cfg_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < RANGES; j++) begin
          rng_q[j] <= '0;
          ilv_q[j] <= '0;
        end
        route_q <= '0;
        node_q  <= '0;
      end else if (hit_s) begin
        case (cfg_kind_e'(cfg_kind))
          K_RANGE: if (slot_ok) rng_q[cfg_slot] <= cfg_wdata;
          K_ILV:   if (slot_ok) ilv_q[cfg_slot] <= cfg_wdata;
          K_ROUTE: route_q <= cfg_wdata;
          K_NODE:  node_q  <= cfg_wdata[3:0];
          default: ;
        endcase
      end
    end

    assign range_by_set[s] = rng_q[rd_slot];
    assign ilv_by_set[s]   = ilv_q[rd_slot];
    assign route_by_set[s] = route_q;
    assign node_src[s]     = node_q[2:0];
    assign node_pres[s]    = node_q[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_top  <= '0;
      high_top <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == K_LOWTOP)  low_top  <= cfg_wdata;
      if (cfg_kind == K_HIGHTOP) high_top <= cfg_wdata;
    end
  end

  assign rd_range = range_by_set[rd_set];
  assign rd_ilv   = ilv_by_set[rd_set];
  assign rd_route = route_by_set[rd_set];
  assign rd_src   = node_src[rd_set];

endmodule

// File: rtl/sai_node_match.sv
module sai_node_match #(
  parameter int NODES = 4,
  parameter int SET_W = 2
) (
  input  logic [NODES-1:0][2:0] node_src,
  input  logic [NODES-1:0]      node_pres,
  input  logic [2:0]            want,
  output logic                  hit,
  output logic [SET_W-1:0]      sel
);
  // R5: lowest-numbered present set with the wanted id
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int n = NODES - 1; n >= 0; n--) begin
      if (node_pres[n] && node_src[n] == want) begin
        hit = 1'b1;
        sel = SET_W'(n);
      end
    end
  end
endmodule

// File: rtl/sai_chan_resolve.sv
module sai_chan_resolve
  import sai_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [63:0] addr,
  input  logic [31:0] range_w,
  input  logic [31:0] ilv_w,
  output logic [3:0]  tgt,
  output logic        is_remote,
  output logic        mod_on,
  output logic        bad_mode,
  output logic [2:0]  lchan
);
  logic [2:0]  idx;
  logic [63:0] shifted;
  logic [1:0]  m3;
  logic [1:0]  val;

  assign idx       = ilv_index(addr, range_w[2:1]);   // R4
  assign tgt       = ilv_w[4*idx +: 4];
  assign is_remote = ~tgt[3];                         // R5
  assign mod_on    = range_w[27];
  assign bad_mode  = mod_on && (range_w[31:30] == 2'b11); // R7

  always_comb begin
    case (range_w[31:30])
      2'd0:    shifted = addr >> 6;
      2'd1:    shifted = addr >> 8;
      default: shifted = addr >> 12;
    endcase
  end

  assign m3    = mod3(shifted, ADDR_W);
  assign val   = fold_value(range_w[6:5], m3, shifted[0]);   // R8
  assign lchan = mod_on ? {val, tgt[0]} : tgt[2:0];          // R7
endmodule

// File: rtl/sai_decoder.sv
module sai_decoder
  import sai_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NODES  = 4,
  parameter int RANGES = 24,
  localparam int SET_W  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int SLOT_W = $clog2(RANGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_err,
  output logic [2:0]        resp_socket,
  output logic [2:0]        resp_ctrl,
  output logic [1:0]        resp_chan
);

  localparam logic [63:0] FOUR_GIB = 64'h1_0000_0000;
  localparam result_t     FAIL_RES = result_t'(9'b1_000_000_00);

  fsm_e              state_q;
  logic [SET_W-1:0]  set_q;
  logic [SLOT_W-1:0] slot_q;
  logic [63:0]       lo_q;
  logic [63:0]       addr_q;
  logic              hopped_q;
  result_t           res_q;

  logic [31:0]            range_w, ilv_w, route_w, low_top, high_top;
  logic [2:0]             src_w;
  logic [NODES-1:0][2:0]  node_src;
  logic [NODES-1:0]       node_pres;

  sai_cfg_store #(.NODES(NODES), .RANGES(RANGES), .SET_W(SET_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_set(cfg_set), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata),
    .rd_set(set_q), .rd_slot(slot_q),
    .rd_range(range_w), .rd_ilv(ilv_w), .rd_route(route_w), .rd_src(src_w),
    .node_src(node_src), .node_pres(node_pres),
    .low_top(low_top), .high_top(high_top)
  );

  logic [3:0] tgt;
  logic       is_remote, mod_on, bad_mode;
  logic [2:0] lchan;

  sai_chan_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .addr(addr_q), .range_w(range_w), .ilv_w(ilv_w),
    .tgt(tgt), .is_remote(is_remote), .mod_on(mod_on), .bad_mode(bad_mode), .lchan(lchan)
  );

  logic             node_hit;
  logic [SET_W-1:0] node_sel;

  sai_node_match #(.NODES(NODES), .SET_W(SET_W)) u_match (
    .node_src(node_src), .node_pres(node_pres), .want(tgt[2:0]),
    .hit(node_hit), .sel(node_sel)
  );

  // Named events
  logic [63:0] req_ext, low_b, high_b, lim;
  logic        accept, out_range, ent_hit, last_slot, restart_ev, resolve_ok;

  assign req_ext    = 64'(req_addr);
  assign low_b      = {6'd0, low_top, 26'd0};
  assign high_b     = {6'd0, high_top, 26'd0};
  assign out_range  = (req_ext >= high_b) || (req_ext >= low_b && req_ext < FOUR_GIB); // R2
  assign accept     = req_valid && req_ready;
  assign lim        = range_limit(range_w);
  assign ent_hit    = (state_q == ST_SCAN) && range_w[0] && (addr_q >= lo_q) && (addr_q <= lim); // R3
  assign last_slot  = (32'(slot_q) == RANGES - 1);
  assign restart_ev = (state_q == ST_RESOLVE) && is_remote && !hopped_q && node_hit;
  assign resolve_ok = (state_q == ST_RESOLVE) && !is_remote && !bad_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      set_q    <= '0;
      slot_q   <= '0;
      lo_q     <= '0;
      addr_q   <= '0;
      hopped_q <= 1'b0;
      res_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q   <= req_ext;
          set_q    <= '0;
          slot_q   <= '0;
          lo_q     <= '0;
          hopped_q <= 1'b0;
          if (out_range) begin
            res_q   <= FAIL_RES;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (ent_hit) begin
            state_q <= ST_RESOLVE;
          end else if (last_slot) begin
            res_q   <= FAIL_RES;
            state_q <= ST_RESP;
          end else begin
            slot_q <= slot_q + 1'b1;
            lo_q   <= lim + 64'd1;
          end
        end
        ST_RESOLVE: begin
          if (restart_ev) begin
            set_q    <= node_sel;
            slot_q   <= '0;
            lo_q     <= '0;
            hopped_q <= 1'b1;
            state_q  <= ST_SCAN;
          end else if (resolve_ok) begin
            res_q.err    <= 1'b0;
            res_q.socket <= src_w;
            res_q.ctrl   <= route_ctrl(route_w, lchan);
            res_q.chan   <= route_chan(route_w, lchan);
            state_q      <= ST_RESP;
          end else begin
            res_q   <= FAIL_RES;
            state_q <= ST_RESP;
          end
        end
        default: if (resp_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign resp_valid  = (state_q == ST_RESP);
  assign resp_err    = res_q.err;
  assign resp_socket = res_q.socket;
  assign resp_ctrl   = res_q.ctrl;
  assign resp_chan   = res_q.chan;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> (resp_socket == 3'd0 && resp_ctrl == 3'd0 && resp_chan == 2'd0)); // R10

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable({resp_err, resp_socket, resp_ctrl, resp_chan})); // R11

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R11

  AST_EARLY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && out_range |=> resp_valid && resp_err); // R2

  AST_SECOND_HOP_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE) && is_remote && hopped_q |=> resp_valid && resp_err); // R6

  AST_MODE3_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE) && !is_remote && bad_mode |=> resp_valid && resp_err); // R7

endmodule

// File: tb/sai_decoder_test.sv
`timescale 1ns/1ps
module sai_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_kind = '0;
  logic [1:0]  cfg_set = '0;
  logic [4:0]  cfg_slot = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_err;
  logic [2:0]  resp_socket, resp_ctrl;
  logic [1:0]  resp_chan;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sai_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_set(cfg_set), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_err(resp_err), .resp_socket(resp_socket), .resp_ctrl(resp_ctrl), .resp_chan(resp_chan)
  );

  // Bench copy of the configuration
  bit [31:0]       m_rng [4][24];
  bit [31:0]       m_ilv [4][24];
  bit [31:0]       m_route [4];
  int              m_src [4];
  bit              m_pres [4];
  longint unsigned m_low, m_high;

  // R13: kind 0 range, 1 interleave, 2 route, 3 node word, 4 low top, 5 high top
  task automatic wr(input int k, input int s, input int sl, input bit [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'(k); cfg_set = 2'(s); cfg_slot = 5'(sl); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic void model(input longint unsigned a, output bit e, output int so,
                                output int ct, output int ch, output int lat, output string tag);
    int tbl;
    bit hop;
    int gsh [4];
    gsh[0] = 6; gsh[1] = 8; gsh[2] = 12; gsh[3] = 30;
    tbl = 0; hop = 0; e = 1; so = 0; ct = 0; ch = 0; lat = 0; tag = "R2";
    if (a >= m_high || (a >= m_low && a < 64'h1_0000_0000)) return;
    forever begin
      longint unsigned lo, lim, w, x;
      int hit, idx, t, L, mm, sh, v, nxt;
      lo = 0; hit = -1;
      for (int i = 0; i < 24; i++) begin
        lim = ((64'(m_rng[tbl][i]) >> 7) & 64'hFFFFF) * 64'h400_0000 + 64'h3FF_FFFF;
        if (hit < 0 && m_rng[tbl][i][0] && a >= lo && a <= lim) hit = i;
        lo = lim + 1;
      end
      if (hit < 0) begin lat += 24; tag = "R3"; return; end
      lat += hit + 2;
      w = 64'(m_rng[tbl][hit]);
      idx = int'((a >> gsh[int'((w >> 1) & 3)]) & 7);          // R4
      t = int'((64'(m_ilv[tbl][hit]) >> (4 * idx)) & 15);
      if (t < 8) begin
        if (hop) begin tag = "R6"; return; end
        nxt = -1;
        for (int n = 3; n >= 0; n--) if (m_pres[n] && m_src[n] == t) nxt = n;
        if (nxt < 0) begin tag = "R6"; return; end
        hop = 1; tbl = nxt;
        continue;
      end
      if (((w >> 27) & 1) == 0) begin
        L = t % 8; tag = "R4/R9";
      end else begin
        mm = int'((w >> 30) & 3);
        if (mm == 3) begin tag = "R7"; return; end
        sh = (mm == 0) ? 6 : (mm == 1) ? 8 : 12;
        x = a >> sh;
        case (int'((w >> 5) & 3))
          0: v = int'(x % 3);
          1: v = int'(x % 2);
          2: v = (x % 2 == 1) ? 2 : 1;
          default: v = int'(x % 2) * 2;
        endcase
        L = v * 2 + (t % 2); tag = "R8";
      end
      if (hop) tag = {tag, "/R5"};
      e = 0;
      so = m_src[tbl];
      ct = int'((64'(m_route[tbl]) >> (3 * L)) & 7);
      ch = int'((64'(m_route[tbl]) >> (18 + 2 * L)) & 3);
      return;
    end
  endfunction

  task automatic run_lookup(input longint unsigned a);
    bit e; int so, ct, ch, lat, cnt; string tag;
    model(a, e, so, ct, ch, lat, tag);
    if (e) tag = {tag, "/R10"};
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[39:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; cnt = 0;
    while (!resp_valid && cnt < 100) begin @(negedge clk); cnt++; end
    checks++;
    if (resp_err !== e || resp_socket !== 3'(so) || resp_ctrl !== 3'(ct) ||
        resp_chan !== 2'(ch) || cnt != lat) begin
      bad++;
      $display("FAIL %s/R12 addr=%h actual err=%0d sock=%0d ctrl=%0d chan=%0d lat=%0d expected err=%0d sock=%0d ctrl=%0d chan=%0d lat=%0d",
               tag, a, resp_err, resp_socket, resp_ctrl, resp_chan, cnt, e, so, ct, ch, lat);
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    longint unsigned a;
    bit [2:0] s_sock, s_ctrl; bit [1:0] s_chan; bit s_err;
    // Build configuration (R3, R4, R7, R8 variety)
    m_src[0] = 2; m_pres[0] = 1;
    m_src[1] = 5; m_pres[1] = 1;
    m_src[2] = 6; m_pres[2] = 0;
    m_src[3] = 5; m_pres[3] = 1;
    m_route[0] = 32'hA5C3_96E1; m_route[1] = 32'h3B72_D40F;
    m_route[2] = 32'h0; m_route[3] = 32'hFFFF_FFFF;
    m_low = 64'(32) << 26; m_high = 64'(256) << 26;
    for (int i = 0; i < 24; i++) begin
      int limf, en0, md0, md1;
      limf = (i == 0) ? 0 : (i == 1) ? 31 : 64 + (i - 2) * 8 + 7;
      en0 = (i != 0 && i != 7) ? 1 : 0;
      md0 = (i % 3 == 2) ? 1 : 0;
      md1 = i % 2;
      m_rng[0][i] = (32'((i / 3) % 4) << 30) | (32'(md0) << 27) | (32'(limf) << 7) |
                    (32'((i / 2) % 4) << 5) | (32'(i % 4) << 1) | 32'(en0);
      m_rng[1][i] = (32'(i % 3) << 30) | (32'(md1) << 27) | (32'(limf) << 7) |
                    (32'(i % 4) << 5) | (32'((i + 1) % 4) << 1) | 32'd1;
      m_rng[2][i] = 0; m_rng[3][i] = 0;
      m_ilv[0][i] = 0; m_ilv[1][i] = 0; m_ilv[2][i] = 0; m_ilv[3][i] = 0;
      for (int k = 0; k < 8; k++) begin
        int n0, n1;
        n0 = 8 + ((k + i) % 8);
        if (i % 5 == 3) n0 = (k == 7) ? 6 : (k % 2 == 0) ? 5 : n0;
        n1 = (k == 5) ? 2 : 8 + ((k * 3 + i) % 8);
        m_ilv[0][i] |= 32'(n0) << (4 * k);
        m_ilv[1][i] |= 32'(n1) << (4 * k);
      end
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (req_ready !== 1'b1 || resp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 actual ready=%0d valid=%0d expected ready=1 valid=0", req_ready, resp_valid);
    end

    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 24; i++) begin
        wr(0, s, i, m_rng[s][i]);
        wr(1, s, i, m_ilv[s][i]);
      end
      wr(2, s, 0, m_route[s]);
      wr(3, s, 0, (32'(m_pres[s]) << 3) | 32'(m_src[s]));
    end
    wr(4, 0, 0, 32'd32);
    wr(5, 0, 0, 32'd256);
    // R13: a write to slot 24 is ignored, so slot 0 of set 0 keeps its value
    wr(0, 0, 24, 32'hFFFF_FFFF);

    // Directed boundaries: R2 hole and top, R3 disabled first slot and limits
    run_lookup(64'h0000_0000_0000_0100);
    run_lookup(64'h0000_0000_03FF_FFFF);
    run_lookup(64'h0000_0000_0400_0000);
    run_lookup(64'h0000_0000_7FFF_FFFF);
    run_lookup(64'h0000_0000_8000_0000);
    run_lookup(64'h0000_0000_FFFF_FFC0);
    run_lookup(64'h0000_0001_0000_0000);
    run_lookup(64'h0000_0003_FFFF_FFFF);
    run_lookup(64'h0000_0004_0000_0000);
    run_lookup(64'h0000_00FF_FFFF_FFFF);

    // Sweep every 64 MiB granule with two low-bit patterns (R3..R9)
    for (int k = 0; k < 260; k++) begin
      a = (64'(k) << 26) | ((64'(k) * 64'd2654435761) & 64'h3FF_FFFF);
      run_lookup(a);
      a = (64'(k) << 26) | ((64'(k) * 64'd40503 + 64'(k * k) * 64'd977) & 64'h3FF_FFFF);
      run_lookup(a);
    end

    // R11: response held while resp_ready is low; no new request accepted
    resp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 40'h00_0440_0140;
    @(posedge clk);
    @(negedge clk);
    while (!resp_valid) @(negedge clk);
    s_err = resp_err; s_sock = resp_socket; s_ctrl = resp_ctrl; s_chan = resp_chan;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b1 || req_ready !== 1'b0 ||
          {resp_err, resp_socket, resp_ctrl, resp_chan} !== {s_err, s_sock, s_ctrl, s_chan}) begin
        bad++;
        $display("FAIL R11 actual valid=%0d ready=%0d data=%h expected valid=1 ready=0 data=%h",
                 resp_valid, req_ready, {resp_err, resp_socket, resp_ctrl, resp_chan},
                 {s_err, s_sock, s_ctrl, s_chan});
      end
    end
    req_valid = 1'b0;
    resp_ready = 1'b1;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R11 actual valid=%0d ready=%0d expected valid=0 ready=1", resp_valid, req_ready);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule